// File: doc/BRIEF.md
# TLB Miss Capture Registers

This block holds the registers a software TLB-miss handler reads while it searches the page table. When the data side or the instruction side reports a TLB miss, the block latches the failing effective address for that side. In the same cycle it builds the expected first word of the matching page-table entry from the segment register that the address selects. It also records the protection key that the current privilege mode picks from that segment register. The block then raises a one-cycle pulse so that the surrounding core clears both translation enables.

A supervisor handler reads and writes these registers through a small register port. Any user-mode access is refused and reported. When a TLB-load command arrives for one side, the block sends that side's compare word out as the first word of the new TLB entry. The port is governed by a three-state machine:

- `PORT_IDLE` is the resting state.
- `PORT_RESP` holds for the cycle after an accepted supervisor read, while the read data is presented.
- `PORT_FAULT` holds for the cycle after any user-mode access.

Every state is entered again from any state in each cycle: a supervisor read leads to `PORT_RESP`, a user access leads to `PORT_FAULT`, and anything else leads to `PORT_IDLE`.

Top module: `tlb_miss_capture`

## Requirements
- R1: After reset, every register reads as zero, and `reg_rvalid`, `priv_err`, `tlb_w0_vld` and `xlat_clr` are low.
- R2: A cycle with `dmiss_evt` high loads `dmiss_ea` into the data miss register, at address 0. A cycle with `imiss_evt` high loads `imiss_ea` into the instruction miss register, at address 1. The new value is readable from the next cycle on.
- R3: When `le_mode` is 1, the data address arrives in little-endian form, with its bits [2:0] inverted. The data miss register stores the address with those three bits inverted back. The instruction side is never altered.
- R4: On a miss, the compare word for that side is built as follows. Address 2 holds the data side and address 3 the instruction side. Bit 31 is the valid bit, set to 1. Bits [30:7] are the segment ID, taken from bits [23:0] of the segment register selected by address bits [31:28]. Bit 6 is the hash select, set to 0. Bits [5:0] are the abbreviated page index, taken from address bits [27:22]. Segment i occupies `seg_regs[32*i+31:32*i]`.
- R5: On a miss, the key bit for that side is stored at address 4: bit 0 holds the data key and bit 1 holds the instruction key. The key is bit 30 of the selected segment register when `user_mode` is 0, and bit 29 when `user_mode` is 1.
- R6: A supervisor read (`reg_rd` high with `user_mode` low) raises `reg_rvalid` in the next cycle, with `reg_rdata` holding the value the register had before that edge. Unmapped addresses 5 to 7 read as zero.
- R7: A supervisor write to addresses 0 to 3 replaces the whole word. A write to address 4 replaces bits [1:0]. The write takes effect from the next cycle.
- R8: A read or write with `user_mode` high changes no register and gives no `reg_rvalid`. Instead, `priv_err` is high for exactly the next cycle.
- R9: When a miss and a supervisor write target the same register in one cycle, the miss capture wins.
- R10: `tlb_ld_d` makes `tlb_w0_vld` high in the next cycle, with `tlb_w0` equal to the data compare word from before the edge and `tlb_w0_inst` equal to 0. `tlb_ld_i` does the same with the instruction compare word and `tlb_w0_inst` equal to 1. If both commands arrive in one cycle, the data command is served.
- R11: `xlat_clr` is high in the cycle after any cycle with a data or instruction miss, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, segment i in bits [32i+31:32i] |
| user_mode | input | 1 | Current privilege, 1 = user |
| le_mode | input | 1 | Little-endian data addressing active |
| dmiss_evt | input | 1 | Data TLB miss |
| dmiss_ea | input | 32 | Effective address of the data miss |
| imiss_evt | input | 1 | Instruction TLB miss |
| imiss_ea | input | 32 | Effective address of the instruction miss |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| priv_err | output | 1 | User-mode access refused |
| tlb_ld_d | input | 1 | Load data-side TLB entry |
| tlb_ld_i | input | 1 | Load instruction-side TLB entry |
| tlb_w0 | output | 32 | First word for the new TLB entry |
| tlb_w0_vld | output | 1 | tlb_w0 valid |
| tlb_w0_inst | output | 1 | tlb_w0 belongs to the instruction side |
| xlat_clr | output | 1 | Pulse to clear the translation enables |

## Verification
The embedded properties check the following in every cycle:
- the fixed fields of the data compare word after a capture;
- that a miss overrides a simultaneous write;
- that a user write leaves the data address untouched;
- the one-cycle fault and read-response pulses;
- the TLB-load word;
- the translation-clear pulse.

Only the bench's scenarios can show the rest. That covers segment selection across all sixteen entries, and the privilege-dependent choice of key. It also covers the little-endian correction, the instruction-side behaviour, the register map including its unmapped holes, and the ordering of reads against writes made in the same cycle.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned VSID_W  = 24;
    localparam int unsigned API_W   = 6;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned SIDES   = 2;

    localparam logic [ADDR_W-1:0] A_MISS_BASE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP_BASE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_KEYS      = 3'd4;

    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_RESP  = 2'd1,
        PORT_FAULT = 2'd2
    } port_state_e;
endpackage

// File: rtl/tmc_cmp_build.sv
module tmc_cmp_build #(
    parameter int unsigned SEG_COUNT = 16
) (
    input  logic [SEG_COUNT*32-1:0] seg_flat,
    input  logic [31:0]             ea,
    input  logic                    user_mode,
    output logic [31:0]             cmp_word,
    output logic                    key_bit
);
    import tmc_pkg::*;
    localparam int unsigned SEL_W = $clog2(SEG_COUNT);

    logic [SEL_W-1:0] sel;
    logic [31:0]      seg;

    always_comb begin
        sel      = ea[31 -: SEL_W];
        seg      = seg_flat[32*sel +: 32];
        // valid, segment id, primary hash, abbreviated page index
        cmp_word = {1'b1, seg[VSID_W-1:0], 1'b0, ea[31-SEL_W -: API_W]};
        key_bit  = user_mode ? seg[29] : seg[30];
    end
endmodule

// File: rtl/tmc_port_fsm.sv
module tmc_port_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    input  logic user_mode,
    output logic rd_take,
    output logic wr_take,
    output logic rd_valid,
    output logic priv_err
);
    import tmc_pkg::*;

    port_state_e state_q, state_d;

    always_comb begin
        rd_take = rd && !user_mode;
        wr_take = wr && !user_mode;
        if ((rd || wr) && user_mode) state_d = PORT_FAULT;
        else if (rd)                 state_d = PORT_RESP;
        else                         state_d = PORT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rd_valid = 1'b0;
        priv_err = 1'b0;
        unique case (state_q)
            PORT_IDLE:  ;
            PORT_RESP:  rd_valid = 1'b1;
            PORT_FAULT: priv_err = 1'b1;
            default:    ;
        endcase
    end

    AST_USER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd || wr) && user_mode) |=> (priv_err && !rd_valid)); // R8
    AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !user_mode) |=> (rd_valid && !priv_err)); // R6
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !((rd || wr) && user_mode) |=> !priv_err); // R8
endmodule

// File: rtl/tlb_miss_capture.sv
module tlb_miss_capture #(
    parameter int unsigned SEG_COUNT = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SEG_COUNT*32-1:0] seg_regs,
    input  logic                    user_mode,
    input  logic                    le_mode,
    input  logic                    dmiss_evt,
    input  logic [31:0]             dmiss_ea,
    input  logic                    imiss_evt,
    input  logic [31:0]             imiss_ea,
    input  logic                    reg_rd,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    reg_rvalid,
    output logic                    priv_err,
    input  logic                    tlb_ld_d,
    input  logic                    tlb_ld_i,
    output logic [31:0]             tlb_w0,
    output logic                    tlb_w0_vld,
    output logic                    tlb_w0_inst,
    output logic                    xlat_clr
);
    import tmc_pkg::*;
    localparam int unsigned SEL_W = $clog2(SEG_COUNT);

    logic        rd_take, wr_take;
    logic        evt    [SIDES];
    logic [31:0] ea_fix [SIDES];
    logic [31:0] miss_w [SIDES];
    logic [31:0] cmp_w  [SIDES];
    logic        key_w  [SIDES];

    always_comb begin
        evt[0]    = dmiss_evt;
        evt[1]    = imiss_evt;
        // data address is always held in big-endian form
        ea_fix[0] = le_mode ? {dmiss_ea[31:3], ~dmiss_ea[2:0]} : dmiss_ea;
        ea_fix[1] = imiss_ea;
    end

    tmc_port_fsm u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .user_mode(user_mode),
        .rd_take  (rd_take),
        .wr_take  (wr_take),
        .rd_valid (reg_rvalid),
        .priv_err (priv_err)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        logic [31:0] cmp_new;
        logic        key_new;
        logic [31:0] miss_r, cmp_r;
        logic        key_r;

        tmc_cmp_build #(.SEG_COUNT(SEG_COUNT)) u_build (
            .seg_flat (seg_regs),
            .ea       (ea_fix[s]),
            .user_mode(user_mode),
            .cmp_word (cmp_new),
            .key_bit  (key_new)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                miss_r <= '0;
                cmp_r  <= '0;
                key_r  <= 1'b0;
            end else if (evt[s]) begin
                miss_r <= ea_fix[s];
                cmp_r  <= cmp_new;
                key_r  <= key_new;
            end else if (wr_take) begin
                if (reg_addr == A_MISS_BASE + ADDR_W'(s)) miss_r <= reg_wdata;
                if (reg_addr == A_CMP_BASE + ADDR_W'(s))  cmp_r  <= reg_wdata;
                if (reg_addr == A_KEYS)                   key_r  <= reg_wdata[s];
            end
        end

        assign miss_w[s] = miss_r;
        assign cmp_w[s]  = cmp_r;
        assign key_w[s]  = key_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata   <= '0;
            tlb_w0      <= '0;
            tlb_w0_vld  <= 1'b0;
            tlb_w0_inst <= 1'b0;
            xlat_clr    <= 1'b0;
        end else begin
            if (rd_take) begin
                unique case (reg_addr)
                    3'd0:    reg_rdata <= miss_w[0];
                    3'd1:    reg_rdata <= miss_w[1];
                    3'd2:    reg_rdata <= cmp_w[0];
                    3'd3:    reg_rdata <= cmp_w[1];
                    3'd4:    reg_rdata <= {30'd0, key_w[1], key_w[0]};
                    default: reg_rdata <= '0;
                endcase
            end
            tlb_w0_vld <= tlb_ld_d || tlb_ld_i;
            if (tlb_ld_d) begin
                tlb_w0      <= cmp_w[0];
                tlb_w0_inst <= 1'b0;
            end else if (tlb_ld_i) begin
                tlb_w0      <= cmp_w[1];
                tlb_w0_inst <= 1'b1;
            end
            xlat_clr <= dmiss_evt || imiss_evt;
        end
    end

    AST_DCMP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        dmiss_evt |=> (cmp_w[0][31] && !cmp_w[0][6] &&
                       cmp_w[0][5:0] == $past(dmiss_ea[31-SEL_W -: API_W]))); // R4
    AST_MISS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dmiss_evt && reg_wr) |=> (miss_w[0] == $past(ea_fix[0]))); // R9
    AST_USER_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && user_mode && !dmiss_evt) |=> $stable(miss_w[0])); // R8
    AST_TLB_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_ld_d |=> (tlb_w0_vld && !tlb_w0_inst && tlb_w0 == $past(cmp_w[0]))); // R10
    AST_XLAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (dmiss_evt || imiss_evt) |=> xlat_clr); // R11
endmodule

// File: tb/tlb_miss_capture_bench.sv
module tlb_miss_capture_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] seg_regs = '0;
    logic         user_mode = 0, le_mode = 0;
    logic         dmiss_evt = 0, imiss_evt = 0;
    logic [31:0]  dmiss_ea = '0, imiss_ea = '0;
    logic         reg_rd = 0, reg_wr = 0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         reg_rvalid, priv_err;
    logic         tlb_ld_d = 0, tlb_ld_i = 0;
    logic [31:0]  tlb_w0;
    logic         tlb_w0_vld, tlb_w0_inst, xlat_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [31:0] m_miss [2];
    logic [31:0] m_cmp  [2];
    logic [1:0]  m_key;
    logic [31:0] e_rdata, e_tlb;
    logic        e_rv, e_pe, e_tv, e_ti, e_xc;

    always #2 clk = ~clk;

    tlb_miss_capture u_tlb_miss_capture (
        .clk(clk), .rst_n(rst_n), .seg_regs(seg_regs), .user_mode(user_mode),
        .le_mode(le_mode), .dmiss_evt(dmiss_evt), .dmiss_ea(dmiss_ea),
        .imiss_evt(imiss_evt), .imiss_ea(imiss_ea), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .priv_err(priv_err),
        .tlb_ld_d(tlb_ld_d), .tlb_ld_i(tlb_ld_i), .tlb_w0(tlb_w0),
        .tlb_w0_vld(tlb_w0_vld), .tlb_w0_inst(tlb_w0_inst), .xlat_clr(xlat_clr)
    );

    function automatic logic [31:0] seg_of(input logic [31:0] ea);
        return seg_regs[32*ea[31:28] +: 32];
    endfunction

    function automatic logic [31:0] exp_cmp(input logic [31:0] ea);
        logic [31:0] s = seg_of(ea);
        return {1'b1, s[23:0], 1'b0, ea[27:22]};
    endfunction

    function automatic logic exp_key(input logic [31:0] ea, input logic usr);
        logic [31:0] s = seg_of(ea);
        return usr ? s[29] : s[30];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string rd_req(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R2";
            3'd2, 3'd3: return "R4";
            3'd4:       return "R5";
            default:    return "R6";
        endcase
    endfunction

    // one cycle: inputs already driven; predict, clock, compare at negedge
    task automatic step();
        logic [31:0] dfix;
        @(posedge clk);
        e_rv = reg_rd && !user_mode;
        e_pe = (reg_rd || reg_wr) && user_mode;
        if (e_rv) begin
            case (reg_addr)
                3'd0: e_rdata = m_miss[0];
                3'd1: e_rdata = m_miss[1];
                3'd2: e_rdata = m_cmp[0];
                3'd3: e_rdata = m_cmp[1];
                3'd4: e_rdata = {30'd0, m_key};
                default: e_rdata = '0;
            endcase
        end
        e_tv = tlb_ld_d || tlb_ld_i;
        e_ti = !tlb_ld_d;
        e_tlb = tlb_ld_d ? m_cmp[0] : m_cmp[1];
        e_xc = dmiss_evt || imiss_evt;
        if (reg_wr && !user_mode) begin
            if (reg_addr == 3'd0 && !dmiss_evt) m_miss[0] = reg_wdata;
            if (reg_addr == 3'd1 && !imiss_evt) m_miss[1] = reg_wdata;
            if (reg_addr == 3'd2 && !dmiss_evt) m_cmp[0] = reg_wdata;
            if (reg_addr == 3'd3 && !imiss_evt) m_cmp[1] = reg_wdata;
            if (reg_addr == 3'd4) begin
                if (!dmiss_evt) m_key[0] = reg_wdata[0];
                if (!imiss_evt) m_key[1] = reg_wdata[1];
            end
        end
        dfix = le_mode ? {dmiss_ea[31:3], ~dmiss_ea[2:0]} : dmiss_ea;
        if (dmiss_evt) begin
            m_miss[0] = dfix; m_cmp[0] = exp_cmp(dfix); m_key[0] = exp_key(dfix, user_mode);
        end
        if (imiss_evt) begin
            m_miss[1] = imiss_ea; m_cmp[1] = exp_cmp(imiss_ea); m_key[1] = exp_key(imiss_ea, user_mode);
        end
        @(negedge clk);
        check("R6 rvalid", 32'(reg_rvalid), 32'(e_rv));
        check("R8 priv_err", 32'(priv_err), 32'(e_pe));
        check("R11 xlat_clr", 32'(xlat_clr), 32'(e_xc));
        check("R10 tlb_vld", 32'(tlb_w0_vld), 32'(e_tv));
        if (e_tv) begin
            check("R10 tlb_word", tlb_w0, e_tlb);
            check("R10 tlb_side", 32'(tlb_w0_inst), 32'(e_ti));
        end
        if (e_rv && reg_rvalid) check(rd_req(reg_addr), reg_rdata, e_rdata);
    endtask

    task automatic idle_inputs();
        dmiss_evt = 0; imiss_evt = 0; reg_rd = 0; reg_wr = 0;
        tlb_ld_d = 0; tlb_ld_i = 0; user_mode = 0; le_mode = 0;
    endtask

    task automatic sup_read(input logic [2:0] a);
        idle_inputs(); reg_rd = 1; reg_addr = a; step(); idle_inputs();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) seg_regs[32*i +: 32] = $urandom(32'h5EED + i);
        m_miss[0] = '0; m_miss[1] = '0; m_cmp[0] = '0; m_cmp[1] = '0; m_key = '0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset release
        check("R1 rvalid", 32'(reg_rvalid), 0);
        check("R1 xlat_clr", 32'(xlat_clr), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 tlb_vld", 32'(tlb_w0_vld), 0);
        check("R1 priv_err", 32'(priv_err), 0);
        for (int a = 0; a < 8; a++) sup_read(3'(a)); // R1 all registers zero

        // R2/R4/R5 supervisor data miss, segment 15
        idle_inputs(); dmiss_evt = 1; dmiss_ea = 32'hF7C0_1234; step();
        idle_inputs(); sup_read(3'd0); sup_read(3'd2); sup_read(3'd4);
        // R5 user-mode instruction miss picks the other key bit
        idle_inputs(); imiss_evt = 1; user_mode = 1; imiss_ea = 32'h3ABC_D000; step();
        sup_read(3'd1); sup_read(3'd3); sup_read(3'd4);
        // R3 little-endian data correction
        idle_inputs(); le_mode = 1; dmiss_evt = 1; dmiss_ea = 32'h1234_5675; step();
        sup_read(3'd0);
        check("R3 low bits", {29'd0, m_miss[0][2:0]}, 32'd2);
        // R7 supervisor write then read, key write
        idle_inputs(); reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'hDEAD_BEEF; step();
        sup_read(3'd3);
        idle_inputs(); reg_wr = 1; reg_addr = 3'd4; reg_wdata = 32'hFFFF_FFFE; step();
        sup_read(3'd4);
        // R8 user write ignored
        idle_inputs(); user_mode = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h0; step();
        sup_read(3'd0);
        // R9 miss beats simultaneous write
        idle_inputs(); reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h1111_1111;
        dmiss_evt = 1; dmiss_ea = 32'h8000_0040; step();
        sup_read(3'd0);
        // R10 both loads: data served
        idle_inputs(); tlb_ld_d = 1; tlb_ld_i = 1; step();
        idle_inputs(); tlb_ld_i = 1; step();

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle_inputs();
            r = $urandom % 100;
            user_mode = (r < 15);
            le_mode   = $urandom % 2;
            dmiss_evt = ($urandom % 6) == 0;
            imiss_evt = ($urandom % 6) == 0;
            dmiss_ea  = $urandom;
            imiss_ea  = $urandom;
            reg_rd    = ($urandom % 3) == 0;
            reg_wr    = ($urandom % 5) == 0;
            reg_addr  = 3'($urandom % 8);
            reg_wdata = $urandom;
            tlb_ld_d  = ($urandom % 7) == 0;
            tlb_ld_i  = ($urandom % 7) == 0;
            if (n % 500 == 499) seg_regs[32*($urandom % 16) +: 32] = $urandom;
            step();
        end
        idle_inputs();
        for (int a = 0; a < 5; a++) sup_read(3'(a));
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule